// File: doc/BRIEF.md
# Processor Interrupt Priority Selector

This block keeps a pending flag for each of seven interrupt sources and, every cycle, names the one interrupt the core should take next. Which source wins is not a fixed ranking. It depends on whether the core runs in hypervisor-privileged mode, on the interrupt-enable bit, on the trap-level-zero enable and the current trap level, and on how the highest pending software level compares with the processor interrupt level. Platform interrupt vectors rank between the low software levels and the high ones.

The choice is combinational from the flags and the state inputs. The core looks at the valid flag, the cause code and the level. It then pulses the take strobe for one cycle, and the winning source is cleared at the next clock edge. A counter of outstanding interrupts drives the any-pending output. A software-interrupt take keeps its flag set while other software levels remain in the soft register.

Top module: `irq_priority_sel`

## Requirements
- R1: While reset is asserted, and after it is released with nothing posted, all flags are clear: `any_pending_o`, `irq_valid_o`, `irq_cause_o` and `irq_level_o` are all 0.
- R2: A post strobe sets its source's flag at the next edge. Post bit index to source: 0 trap-level-zero, 1 hypervisor tick, 2 platform vector, 3 CPU queue, 4 device queue, 5 resumable error, 6 soft interrupt. A post to a source that is already pending is merged with it. `any_pending_o` is high exactly when the outstanding count, meaning the number of pending sources, is nonzero.
- R3: In hypervisor-privileged mode nothing is offered while interrupt enable is low. With enable high, hypervisor tick wins over platform vector. No other source is ever offered in this mode.
- R4: Outside hypervisor mode, trap-level-zero has the top priority, but it is offered only when its enable bit is set and the trap level is 0.
- R5: Outside hypervisor mode, hypervisor tick comes next, whatever the interrupt-enable bit is.
- R6: Outside hypervisor mode with interrupt enable high, the order continues with CPU queue, then device queue, then the soft-interrupt logic. With enable low, none of these three is offered.
- R7: The soft level is the index of the highest set bit among bits 15..1 of the soft register. Bit 0 is ignored, and the level is 0 when no such bit is set. When the soft flag is pending, a level below 6 with a platform vector pending offers the platform vector instead.
- R8: Otherwise a pending soft interrupt is offered only when its level is strictly greater than the PIL, and the level is reported on `irq_level_o`.
- R9: Taking a soft interrupt clears its flag only when no soft-register bit in 15..1 other than the taken level is set. Otherwise the flag stays pending.
- R10: Resumable error has the lowest priority outside hypervisor mode and does not need interrupt enable.
- R11: A take while valid clears the offered source at the next edge and lowers the count by one. A take while nothing is valid changes nothing. A post and a take of the same source in one cycle leave it pending.
- R12: Cause codes are 0 none, 1 trap-level-zero, 2 hypervisor tick, 3 platform vector, 4 CPU queue, 5 device queue, 6 resumable error, 7 soft interrupt. `irq_level_o` is 0 for every cause except 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| post_i | input | 7 | One post strobe per source |
| hyp_priv_i | input | 1 | Hypervisor-privileged mode |
| int_en_i | input | 1 | Interrupt enable |
| tlz_en_i | input | 1 | Trap-level-zero interrupt enable |
| trap_lvl_i | input | TL_W (3) | Current trap level |
| soft_reg_i | input | SOFT_W (16) | Software interrupt register |
| pil_i | input | PIL_W (4) | Processor interrupt level |
| take_i | input | 1 | Core accepts the offered interrupt this cycle |
| any_pending_o | output | 1 | At least one source pending |
| irq_valid_o | output | 1 | An interrupt is offered |
| irq_cause_o | output | 3 | Cause code of the offered interrupt |
| irq_level_o | output | LVL_W (4) | Soft level, 0 for other causes |

## Verification
The assertions assume that all inputs change only away from the rising edge. They also assume that the state inputs (mode, enables, trap level, soft register, PIL) hold steady across the cycle in which the take strobe is high, so the offered cause and the one that is cleared agree. The bench drives every input at the falling edge and keeps the values for the whole cycle. Its random phase posts sparsely and mixes in many cycles with an empty soft register and trap level 0, so that the enable, trap-level and PIL comparisons are all reached.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

  localparam int NUM_SRC = 7;
  localparam int CAUSE_W = 3;

  // source slot in the pending vector
  localparam int SRC_TLZ   = 0;
  localparam int SRC_HTICK = 1;
  localparam int SRC_VEC   = 2;
  localparam int SRC_CPUQ  = 3;
  localparam int SRC_DEVQ  = 4;
  localparam int SRC_RERR  = 5;
  localparam int SRC_SOFT  = 6;

  // cause code is source slot plus one, zero means nothing offered
  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE  = 3'd0,
    CAUSE_TLZ   = 3'd1,
    CAUSE_HTICK = 3'd2,
    CAUSE_VEC   = 3'd3,
    CAUSE_CPUQ  = 3'd4,
    CAUSE_DEVQ  = 3'd5,
    CAUSE_RERR  = 3'd6,
    CAUSE_SOFT  = 3'd7
  } cause_e;

endpackage

// File: rtl/irq_soft_level.sv
module irq_soft_level #(
  parameter int SOFT_W = 16,
  parameter int LVL_W  = $clog2(SOFT_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SOFT_W-1:0] soft_reg_i,
  output logic [LVL_W-1:0]  level_o,
  output logic              others_o
);

  logic [SOFT_W-1:0] rest;

  // highest set bit above bit 0; bit 0 never forms a level
  always_comb begin
    level_o = '0;
    for (int i = 1; i < SOFT_W; i++) begin
      if (soft_reg_i[i]) level_o = LVL_W'(i);
    end
  end

  // anything left once the chosen level and bit 0 are masked away
  always_comb begin
    rest          = soft_reg_i;
    rest[0]       = 1'b0;
    rest[level_o] = 1'b0;
    others_o      = |rest;
  end

  a_r7_level_is_set_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (level_o != '0) |-> soft_reg_i[level_o]);

  a_r7_nothing_above: assert property (@(posedge clk) disable iff (!rst_n)
    ((soft_reg_i >> level_o) >> 1) == '0);

  a_r9_others_means_more: assert property (@(posedge clk) disable iff (!rst_n)
    others_o |-> ($countones(soft_reg_i[SOFT_W-1:1]) >= 2));

endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] post_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);

  logic [N-1:0] flag_d;
  logic [N-1:0] flag_en;

  for (genvar g = 0; g < N; g++) begin : g_slot
    // a post wins over a clear in the same cycle
    always_comb begin
      flag_en[g] = post_i[g] | clr_i[g];
      flag_d[g]  = post_i[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flags_o[g] <= 1'b0;
      else if (flag_en[g]) flags_o[g] <= flag_d[g];
    end

    a_r2_post_sets: assert property (@(posedge clk) disable iff (!rst_n)
      post_i[g] |=> flags_o[g]);

    a_r11_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[g] && !post_i[g]) |=> !flags_o[g]);

    a_r11_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i[g] && !post_i[g]) |=> $stable(flags_o[g]));
  end

endmodule

// File: rtl/irq_post_counter.sv
module irq_post_counter #(
  parameter int N     = 7,
  parameter int CNT_W = $clog2(N + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] post_i,
  input  logic [N-1:0] flags_i,
  input  logic [N-1:0] clr_i,
  output logic         any_pending_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] inc;
  logic             dec;
  logic             cnt_en;

  // a post counts only when it creates a new pending entry
  always_comb begin
    inc = '0;
    for (int i = 0; i < N; i++) begin
      if (post_i[i] && (!flags_i[i] || clr_i[i])) inc = inc + CNT_W'(1);
    end
    dec    = |clr_i;
    cnt_en = (inc != '0) || dec;
    cnt_d  = cnt_q + inc - CNT_W'(dec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign any_pending_o = (cnt_q != '0);

  a_r2_count_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) == $countones(flags_i));

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= N);

  a_r11_single_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_i));

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_sel_pkg::*;
#(
  parameter int LVL_W     = 4,
  parameter int PIL_W     = 4,
  parameter int TL_W      = 3,
  parameter int VEC_SPLIT = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] flags_i,
  input  logic               hyp_i,
  input  logic               ie_i,
  input  logic               tlz_en_i,
  input  logic [TL_W-1:0]    tl_i,
  input  logic [LVL_W-1:0]   soft_lvl_i,
  input  logic               soft_others_i,
  input  logic [PIL_W-1:0]   pil_i,
  input  logic               take_i,
  output logic               valid_o,
  output cause_e             cause_o,
  output logic [LVL_W-1:0]   level_o,
  output logic [NUM_SRC-1:0] clr_o
);

  logic soft_low;
  logic soft_above;
  logic tlz_ok;

  always_comb begin
    soft_low   = int'(soft_lvl_i) < VEC_SPLIT;
    soft_above = int'(soft_lvl_i) > int'(pil_i);
    tlz_ok     = tlz_en_i && (tl_i == '0);
  end

  // mode-dependent priority chain
  always_comb begin
    cause_o = CAUSE_NONE;
    level_o = '0;
    if (hyp_i) begin
      if (ie_i) begin
        if (flags_i[SRC_HTICK])    cause_o = CAUSE_HTICK;
        else if (flags_i[SRC_VEC]) cause_o = CAUSE_VEC;
      end
    end else begin
      if (flags_i[SRC_TLZ] && tlz_ok) begin
        cause_o = CAUSE_TLZ;
      end else if (flags_i[SRC_HTICK]) begin
        cause_o = CAUSE_HTICK;
      end else if (ie_i && flags_i[SRC_CPUQ]) begin
        cause_o = CAUSE_CPUQ;
      end else if (ie_i && flags_i[SRC_DEVQ]) begin
        cause_o = CAUSE_DEVQ;
      end else if (ie_i && flags_i[SRC_SOFT] && soft_low && flags_i[SRC_VEC]) begin
        cause_o = CAUSE_VEC;
      end else if (ie_i && flags_i[SRC_SOFT] && soft_above) begin
        cause_o = CAUSE_SOFT;
        level_o = soft_lvl_i;
      end else if (flags_i[SRC_RERR]) begin
        cause_o = CAUSE_RERR;
      end
    end
    valid_o = (cause_o != CAUSE_NONE);
  end

  // clear strobe for the winning slot; soft keeps its flag while levels remain
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_clr
    if (g == SRC_SOFT) begin : g_soft
      assign clr_o[g] = take_i && (cause_o == cause_e'(g + 1)) && !soft_others_i;
    end else begin : g_plain
      assign clr_o[g] = take_i && (cause_o == cause_e'(g + 1));
    end
  end

  a_r3_hyp_needs_ie: assert property (@(posedge clk) disable iff (!rst_n)
    (hyp_i && !ie_i) |-> !valid_o);

  a_r3_hyp_only_two: assert property (@(posedge clk) disable iff (!rst_n)
    (hyp_i && valid_o) |-> (cause_o == CAUSE_HTICK || cause_o == CAUSE_VEC));

  a_r4_tlz_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_o == CAUSE_TLZ) |-> (!hyp_i && tlz_en_i && tl_i == '0 && flags_i[SRC_TLZ]));

  a_r8_soft_above_pil: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_o == CAUSE_SOFT) |-> (int'(level_o) > int'(pil_i)));

  a_r10_rerr_last: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_o == CAUSE_RERR) |-> (!hyp_i && !flags_i[SRC_HTICK] && flags_i[SRC_RERR]));

  a_r12_level_only_soft: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_o != CAUSE_SOFT) |-> (level_o == '0));

  a_r11_clear_needs_take: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_o != '0) |-> (take_i && valid_o));

endmodule

// File: rtl/irq_priority_sel.sv
module irq_priority_sel
  import irq_sel_pkg::*;
#(
  parameter int SOFT_W    = 16,
  parameter int PIL_W     = 4,
  parameter int TL_W      = 3,
  parameter int VEC_SPLIT = 6,
  parameter int LVL_W     = $clog2(SOFT_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] post_i,
  input  logic               hyp_priv_i,
  input  logic               int_en_i,
  input  logic               tlz_en_i,
  input  logic [TL_W-1:0]    trap_lvl_i,
  input  logic [SOFT_W-1:0]  soft_reg_i,
  input  logic [PIL_W-1:0]   pil_i,
  input  logic               take_i,
  output logic               any_pending_o,
  output logic               irq_valid_o,
  output logic [CAUSE_W-1:0] irq_cause_o,
  output logic [LVL_W-1:0]   irq_level_o
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic [SYNC_STAGES-1:0] rst_sync_d;
  logic                   rst_int_n;

  logic [NUM_SRC-1:0] flags;
  logic [NUM_SRC-1:0] clr;
  logic [LVL_W-1:0]   soft_lvl;
  logic               soft_others;
  cause_e             cause;

  // reset asserts at once, releases after the sync chain fills
  always_comb rst_sync_d = {rst_sync_q[SYNC_STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= rst_sync_d;
  end

  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  irq_pend_bank #(.N(NUM_SRC)) u_bank (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .post_i  (post_i),
    .clr_i   (clr),
    .flags_o (flags)
  );

  irq_post_counter #(.N(NUM_SRC)) u_count (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .post_i        (post_i),
    .flags_i       (flags),
    .clr_i         (clr),
    .any_pending_o (any_pending_o)
  );

  irq_soft_level #(.SOFT_W(SOFT_W), .LVL_W(LVL_W)) u_soft (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .soft_reg_i (soft_reg_i),
    .level_o    (soft_lvl),
    .others_o   (soft_others)
  );

  irq_arbiter #(
    .LVL_W     (LVL_W),
    .PIL_W     (PIL_W),
    .TL_W      (TL_W),
    .VEC_SPLIT (VEC_SPLIT)
  ) u_arb (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .flags_i       (flags),
    .hyp_i         (hyp_priv_i),
    .ie_i          (int_en_i),
    .tlz_en_i      (tlz_en_i),
    .tl_i          (trap_lvl_i),
    .soft_lvl_i    (soft_lvl),
    .soft_others_i (soft_others),
    .pil_i         (pil_i),
    .take_i        (take_i),
    .valid_o       (irq_valid_o),
    .cause_o       (cause),
    .level_o       (irq_level_o),
    .clr_o         (clr)
  );

  assign irq_cause_o = cause;

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_int_n)
    !any_pending_o |-> !irq_valid_o);

endmodule

// File: tb/irq_priority_sel_tb.sv
`timescale 1ns/1ps
module irq_priority_sel_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [6:0]  post;
  logic        hyp, ie, tlz;
  logic [2:0]  tl;
  logic [15:0] sreg;
  logic [3:0]  pil;
  logic        take;
  logic        any_p, vld;
  logic [2:0]  cause;
  logic [3:0]  lvl;

  typedef struct {
    logic       v;
    logic [2:0] c;
    logic [3:0] l;
    logic       a;
    string      tag;
  } exp_t;

  exp_t       sb[$];
  logic [6:0] mflags;
  int         errors = 0;
  int         checks = 0;
  bit         done   = 0;

  always #2 clk = ~clk;

  irq_priority_sel u_dut (
    .clk(clk), .rst_n(rst_n), .post_i(post), .hyp_priv_i(hyp), .int_en_i(ie),
    .tlz_en_i(tlz), .trap_lvl_i(tl), .soft_reg_i(sreg), .pil_i(pil), .take_i(take),
    .any_pending_o(any_p), .irq_valid_o(vld), .irq_cause_o(cause), .irq_level_o(lvl)
  );

  // driver: applies one cycle of stimulus, queues the expected outputs, advances the model
  task automatic step(input logic [6:0] p, input logic h, input logic e, input logic z,
                      input logic [2:0] t, input logic [15:0] s, input logic [3:0] pl,
                      input logic tk, input string tag);
    exp_t       x;
    int         lv;
    logic [15:0] rem;
    logic [6:0] clr;
    @(negedge clk);
    post = p; hyp = h; ie = e; tlz = z; tl = t; sreg = s; pil = pl; take = tk;
    lv = 0;
    for (int i = 1; i < 16; i++) if (s[i]) lv = i;
    x.c = 3'd0; x.l = 4'd0; x.tag = tag;
    if (h) begin
      if (e && mflags[1])      x.c = 3'd2;
      else if (e && mflags[2]) x.c = 3'd3;
    end else begin
      if (mflags[0] && z && t == 3'd0)                 x.c = 3'd1;
      else if (mflags[1])                              x.c = 3'd2;
      else if (e && mflags[3])                         x.c = 3'd4;
      else if (e && mflags[4])                         x.c = 3'd5;
      else if (e && mflags[6] && lv < 6 && mflags[2])  x.c = 3'd3;
      else if (e && mflags[6] && lv > int'(pl)) begin x.c = 3'd7; x.l = 4'(lv); end
      else if (mflags[5])                              x.c = 3'd6;
    end
    x.v = (x.c != 3'd0);
    x.a = (mflags != 7'd0);
    sb.push_back(x);
    rem = s & ~(16'd1 << lv) & 16'hFFFE;
    clr = 7'd0;
    if (tk && x.v && !(x.c == 3'd7 && rem != 16'd0)) clr = 7'd1 << (x.c - 3'd1);
    mflags = (mflags & ~clr) | p;
  endtask

  // monitor: compares each queued expectation one time unit after the falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t x;
        x = sb.pop_front();
        checks++;
        if (vld !== x.v || cause !== x.c || lvl !== x.l || any_p !== x.a) begin
          errors++;
          $display("FAIL %s: got v=%0b c=%0d l=%0d any=%0b expected v=%0b c=%0d l=%0d any=%0b",
                   x.tag, vld, cause, lvl, any_p, x.v, x.c, x.l, x.a);
        end
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mflags = 7'd0;
    post = 0; hyp = 0; ie = 0; tlz = 0; tl = 0; sreg = 0; pil = 0; take = 0;
    // R1: reset state, then idle while the internal reset releases
    step(7'h00, 0, 0, 0, 0, 16'h0, 0, 0, "R1 in reset");
    step(7'h00, 0, 0, 0, 0, 16'h0, 0, 1, "R1 in reset");
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(7'h00, 0, 0, 0, 0, 16'h0, 0, 0, "R1 after release");

    // R2: posts of hypervisor tick and resumable error
    step(7'h22, 0, 0, 0, 0, 16'h0, 0, 0, "R2 post cycle");
    step(7'h00, 0, 0, 0, 0, 16'h0, 0, 0, "R2 pending visible");
    step(7'h02, 0, 0, 0, 0, 16'h0, 0, 0, "R2 repeated post merged");
    // R5: tick taken with enable low
    step(7'h00, 0, 0, 0, 0, 16'h0, 0, 1, "R5 tick without enable");
    // R10: resumable error without enable
    step(7'h00, 0, 0, 0, 0, 16'h0, 0, 1, "R10 rerr lowest");
    step(7'h00, 0, 0, 0, 0, 16'h0, 0, 0, "R11 all cleared");
    step(7'h00, 0, 0, 0, 0, 16'h0, 0, 1, "R11 take with nothing valid");

    // R3: hypervisor mode ordering and gating
    step(7'h0E, 1, 0, 0, 0, 16'h0, 0, 0, "R3 post");
    step(7'h00, 1, 0, 0, 0, 16'h0, 0, 1, "R3 enable low hides all");
    step(7'h00, 1, 1, 0, 0, 16'h0, 0, 1, "R3 tick first");
    step(7'h00, 1, 1, 0, 0, 16'h0, 0, 1, "R3 vector second");
    step(7'h00, 1, 1, 0, 0, 16'h0, 0, 0, "R3 queue not offered");
    // R6: queue sources outside hypervisor mode
    step(7'h10, 0, 0, 0, 0, 16'h0, 0, 0, "R6 enable low hides queue");
    step(7'h00, 0, 1, 0, 0, 16'h0, 0, 1, "R6 cpu queue first");
    step(7'h00, 0, 1, 0, 0, 16'h0, 0, 1, "R6 device queue next");

    // R4: trap-level-zero gating
    step(7'h03, 0, 0, 1, 3'd2, 16'h0, 0, 0, "R4 post");
    step(7'h00, 0, 0, 1, 3'd2, 16'h0, 0, 0, "R4 trap level nonzero");
    step(7'h00, 0, 0, 0, 3'd0, 16'h0, 0, 0, "R4 enable low");
    step(7'h00, 0, 0, 1, 3'd0, 16'h0, 0, 1, "R4 taken first");
    step(7'h00, 0, 0, 1, 3'd0, 16'h0, 0, 1, "R5 tick after tlz");

    // R7: vector slotted among soft levels
    step(7'h44, 0, 1, 0, 0, 16'h0021, 0, 0, "R7 post");
    step(7'h00, 0, 1, 0, 0, 16'h0021, 0, 1, "R7 low level yields vector");
    step(7'h00, 0, 1, 0, 0, 16'h0021, 0, 0, "R8 level five above pil");
    step(7'h04, 0, 1, 0, 0, 16'h0041, 0, 0, "R7 post vector");
    step(7'h00, 0, 1, 0, 0, 16'h0041, 0, 0, "R7 level six beats vector");
    step(7'h00, 0, 1, 0, 0, 16'h0041, 4'd6, 0, "R8 level equal to pil");
    step(7'h00, 0, 1, 0, 0, 16'h0041, 4'd6, 1, "R7 falls to vector? no, low check");
    step(7'h00, 0, 1, 0, 0, 16'h0021, 0, 1, "R7 vector taken below six");
    step(7'h00, 0, 1, 0, 0, 16'h0001, 0, 0, "R7 bit zero ignored");
    // R9: partial soft clears
    step(7'h00, 0, 1, 0, 0, 16'h0300, 4'd3, 1, "R9 take with more left");
    step(7'h00, 0, 1, 0, 0, 16'h0300, 4'd3, 0, "R9 still pending");
    step(7'h00, 0, 1, 0, 0, 16'h0200, 4'd3, 1, "R9 last level taken");
    step(7'h00, 0, 1, 0, 0, 16'h0200, 4'd3, 0, "R9 flag cleared");
    // R11: post and take in the same cycle
    step(7'h02, 0, 0, 0, 0, 16'h0, 0, 0, "R11 post");
    step(7'h02, 0, 0, 0, 0, 16'h0, 0, 1, "R11 post with take");
    step(7'h00, 0, 0, 0, 0, 16'h0, 0, 1, "R11 still pending");
    step(7'h00, 0, 0, 0, 0, 16'h0, 0, 0, "R12 idle codes");

    // random mix across all modes
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] s;
      s = ($urandom % 4 == 0) ? 16'h0 : (16'($urandom) >> ($urandom % 16));
      step(7'($urandom) & 7'($urandom) & 7'($urandom),
           1'(($urandom % 4) == 0), 1'($urandom), 1'($urandom),
           ($urandom % 2) ? 3'd0 : 3'($urandom), s, 4'($urandom),
           1'($urandom), "R12 random");
    end

    step(7'h00, 0, 0, 0, 0, 16'h0, 0, 0, "R11 final");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule